// File: doc/BRIEF.md
# Byte-Port Bit-Field Engine

This unit works on a bit field of 1 to 32 bits held in big-endian byte memory. The caller gives a byte base address, a signed bit offset, a 5-bit length and an operation code. The unit works out which bytes hold the field. It fetches them one at a time through a byte-wide request/acknowledge port. It then either reports the field or writes the touched bytes back with the field changed.

Seven operations are provided:

- unsigned and signed extraction;
- insertion of a supplied value;
- inversion, clearing and setting of the field;
- a search for the first one bit, which returns an absolute bit offset.

Bits are counted from the most significant bit of the lowest-addressed byte. A result and a negative flag come back together with a single-cycle completion strobe.

Top module: `bitfield_mem_unit`

## Requirements
- R1: A length input of 0 selects a 32-bit field; any other value v selects v bits.
- R2: The offset is a signed 32-bit bit count. The first byte touched is base + floor(offset/8), and the field starts at bit (offset mod 8) of that byte, a value from 0 to 7.
- R3: Exactly ((offset mod 8) + length − 1)/8 + 1 consecutive bytes are read, in ascending address order. This is one to five bytes.
- R4: Field bit 0 is the most significant bit of the first byte, and field bits run toward less significant bits and then into higher addresses.
- R5: Op code 0 (unsigned extract) returns the field zero-extended. neg equals the field's first bit. Code 7 behaves the same way.
- R6: Op code 1 (signed extract) returns the field sign-extended from its first bit. neg equals that bit.
- R7: Op code 2 (insert) replaces the field with the low `length` bits of ins_val and keeps every other bit of the touched bytes. The result is that inserted value left-justified in 32 bits, and neg is its top bit.
- R8: Op codes 3, 4 and 5 write the field back inverted, all zeros or all ones respectively. Each returns the previous field left-justified in 32 bits, with neg equal to its top bit.
- R9: Op code 6 (find first one) returns offset plus the number of zero bits ahead of the first one bit in the field. If the field is all zero, it returns offset plus length. Memory is left unchanged.
- R10: Each byte transfer holds mem_req, mem_we, mem_addr and mem_wdata steady until mem_ack. All reads finish before the first write. Op codes 0, 1, 6 and 7 never write. Op codes 2 to 5 write each touched byte once.
- R11: After reset, busy, done and mem_req are low. done is high for exactly one cycle after the final transfer of an operation, and busy stays high from the cycle after start until the done cycle.
- R12: A start request while busy is high, including the done cycle, is ignored. It does not change the operation in progress and launches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Operation request, accepted only when idle |
| op | input | 3 | Operation code (0..7) |
| base_addr | input | AW | Byte base address |
| bit_ofs | input | 32 | Signed bit offset |
| field_len | input | 5 | Field length, 0 meaning 32 |
| ins_val | input | 32 | Value for insertion |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | 32 | Operation result, valid from done until next start |
| neg | output | 1 | Negative flag |
| mem_req | output | 1 | Byte transfer request |
| mem_we | output | 1 | Transfer is a write |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Transfer acknowledge |

## Verification
The completion strobe and a fresh start request can fall in the same cycle. A caller that sees a done in the cycle it issues its next request risks either losing that request or silently starting an unintended operation. The bench places a start pulse carrying a field-setting operation exactly in the done cycle of an extraction. It also places another pulse in the middle of an operation. It then judges by the port behaviour that follows: no further memory request, no second done, and memory identical to what the first operation alone leaves.

// File: rtl/bitfield_mem_unit.sv
module bitfield_mem_unit #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    op,
  input  logic [AW-1:0] base_addr,
  input  logic [31:0]   bit_ofs,
  input  logic [4:0]    field_len,
  input  logic [31:0]   ins_val,
  output logic          busy,
  output logic          done,
  output logic [31:0]   result,
  output logic          neg,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  input  logic          mem_ack
);

  localparam int WIN = 40;
  localparam logic [2:0] OP_EXTU = 3'd0, OP_EXTS = 3'd1, OP_INS = 3'd2,
                         OP_CHG  = 3'd3, OP_CLR  = 3'd4, OP_SET = 3'd5,
                         OP_FFO  = 3'd6;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_FIN} state_t;

  state_t          st;
  logic [2:0]      op_q;
  logic [AW-1:0]   addr_q;
  logic [2:0]      bofs_q;
  logic [5:0]      len_q;
  logic [31:0]     ofs_q;
  logic [31:0]     val_q;
  logic [WIN-1:0]  win_q;
  logic [2:0]      idx_q;

  logic [6:0]      span;
  logic [2:0]      last;
  logic            writes;
  logic [5:0]      rsh;
  logic [WIN-1:0]  aligned;
  logic [31:0]     hi_mask, field_lj, ext_u, ext_s, ins_lj;
  logic [WIN-1:0]  mask40, new40;
  logic [5:0]      lead;

  assign span    = ({4'b0, bofs_q} + {1'b0, len_q} - 7'd1) >> 3;
  assign last    = span[2:0];
  assign writes  = (op_q == OP_INS) || (op_q == OP_CHG) ||
                   (op_q == OP_CLR) || (op_q == OP_SET);
  assign rsh     = 6'd32 - len_q;
  assign aligned = win_q << bofs_q;
  assign hi_mask = ~(32'hFFFF_FFFF >> len_q);
  assign field_lj = aligned[WIN-1 -: 32] & hi_mask;
  assign ext_u   = field_lj >> rsh;
  assign ext_s   = $signed(field_lj) >>> rsh;
  assign ins_lj  = val_q << rsh;
  assign mask40  = {hi_mask, 8'h00} >> bofs_q;

  always_comb begin
    case (op_q)
      OP_INS:  new40 = (win_q & ~mask40) | (({ins_lj, 8'h00} >> bofs_q) & mask40);
      OP_CHG:  new40 = win_q ^ mask40;
      OP_CLR:  new40 = win_q & ~mask40;
      OP_SET:  new40 = win_q | mask40;
      default: new40 = win_q;
    endcase
  end

  always_comb begin
    logic hit;
    hit  = 1'b0;
    lead = len_q;
    for (int k = 0; k < 32; k++) begin
      if (!hit && field_lj[31-k]) begin
        hit  = 1'b1;
        lead = 6'(k);
      end
    end
  end

  always_comb begin
    case (op_q)
      OP_EXTS:                 result = ext_s;
      OP_INS:                  result = ins_lj;
      OP_CHG, OP_CLR, OP_SET:  result = field_lj;
      OP_FFO:                  result = ofs_q + {26'b0, lead};
      default:                 result = ext_u;
    endcase
  end

  assign neg       = (op_q == OP_INS) ? ins_lj[31] : field_lj[31];
  assign busy      = (st != S_IDLE);
  assign done      = (st == S_FIN);
  assign mem_req   = (st == S_RD) || (st == S_WR);
  assign mem_we    = (st == S_WR);
  assign mem_addr  = addr_q + AW'(idx_q);
  assign mem_wdata = new40[8*(4-idx_q) +: 8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      op_q   <= '0;
      addr_q <= '0;
      bofs_q <= '0;
      len_q  <= 6'd32;
      ofs_q  <= '0;
      val_q  <= '0;
      win_q  <= '0;
      idx_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          op_q   <= op;
          addr_q <= base_addr + AW'($signed(bit_ofs) >>> 3);
          bofs_q <= bit_ofs[2:0];
          len_q  <= (field_len == 5'd0) ? 6'd32 : {1'b0, field_len};
          ofs_q  <= bit_ofs;
          val_q  <= ins_val;
          win_q  <= '0;
          idx_q  <= '0;
          st     <= S_RD;
        end
        S_RD: if (mem_ack) begin
          win_q[8*(4-idx_q) +: 8] <= mem_rdata;
          if (idx_q == last) begin
            idx_q <= '0;
            st    <= writes ? S_WR : S_FIN;
          end else begin
            idx_q <= idx_q + 3'd1;
          end
        end
        S_WR: if (mem_ack) begin
          if (idx_q == last) st <= S_FIN;
          else idx_q <= idx_q + 3'd1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  a_r10_writes_run_to_done: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> mem_we || done);

  a_r12_busy_ignores_start: assert property (@(posedge clk) disable iff (!rst_n)
    start && busy |=> $stable(op_q) && $stable(addr_q) && $stable(len_q) && $stable(ofs_q));

  a_r3_index_in_span: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> idx_q <= last);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !done);

endmodule

// File: tb/tb_bitfield_mem_unit.sv
module tb_bitfield_mem_unit;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int MSZ = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] op = '0;
  logic [AW-1:0] base_addr = '0;
  logic [31:0] bit_ofs = '0, ins_val = '0;
  logic [4:0] field_len = '0;
  logic busy, done, neg, mem_req, mem_we, mem_ack;
  logic [31:0] result;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitfield_mem_unit #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .base_addr(base_addr),
    .bit_ofs(bit_ofs), .field_len(field_len), .ins_val(ins_val), .busy(busy),
    .done(done), .result(result), .neg(neg), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  logic [7:0] mem [MSZ];
  logic [7:0] ref_mem [MSZ];
  int wait_cfg = 0, wcnt = 0, rd_cnt = 0, wr_cnt = 0;
  int fill_seed = 0;
  logic fill_go = 1'b0;
  logic ack_r = 1'b0;
  logic [7:0] rdata_r = '0;
  int total = 0, bad = 0;

  assign mem_ack = ack_r;
  assign mem_rdata = rdata_r;

  function automatic logic [7:0] patt(int seed, int i);
    if (seed < 0) return 8'h00;
    return 8'(seed * 37 + i * 91 + (i >> 2) + 5);
  endfunction

  always @(posedge clk) begin
    if (fill_go) begin
      for (int i = 0; i < MSZ; i++) mem[i] <= patt(fill_seed, i);
    end
    if (mem_req && !ack_r) begin
      if (wcnt >= wait_cfg) begin
        ack_r <= 1'b1;
        wcnt <= 0;
        if (mem_we) begin
          mem[mem_addr[5:0]] <= mem_wdata;
          wr_cnt <= wr_cnt + 1;
        end else begin
          rdata_r <= mem[mem_addr[5:0]];
          rd_cnt <= rd_cnt + 1;
        end
      end else wcnt <= wcnt + 1;
    end else ack_r <= 1'b0;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill(int seed);
    @(negedge clk); fill_seed = seed; fill_go = 1'b1;
    @(negedge clk); fill_go = 1'b0;
  endtask

  // Bit-by-bit reference on ref_mem; returns result, flag and bytes touched
  task automatic model(input logic [2:0] o, input int base, input logic [31:0] ofs,
                       input logic [4:0] ln, input logic [31:0] val,
                       output logic [31:0] er, output logic en, output int nbytes);
    int L; longint p0; logic [63:0] fld; int first1; longint b0, b1;
    L = (ln == 0) ? 32 : int'(ln);
    p0 = longint'(base) * 8 + longint'($signed(ofs));
    fld = '0; first1 = -1;
    for (int k = 0; k < L; k++) begin
      longint p; int by, bt; logic b;
      p = p0 + k; by = int'(p >>> 3); bt = 7 - int'(p & 7);
      b = ref_mem[by][bt];
      fld = {fld[62:0], b};
      if (b && first1 < 0) first1 = k;
      case (o)
        3'd2: ref_mem[by][bt] = val[L-1-k];
        3'd3: ref_mem[by][bt] = ~b;
        3'd4: ref_mem[by][bt] = 1'b0;
        3'd5: ref_mem[by][bt] = 1'b1;
        default: ;
      endcase
    end
    b0 = p0 >>> 3; b1 = (p0 + L - 1) >>> 3;
    nbytes = int'(b1 - b0) + 1;
    case (o)
      3'd1: begin
        er = fld[L-1] ? 32'(fld | ~((64'd1 << L) - 1)) : 32'(fld);
        en = fld[L-1];
      end
      3'd2: begin
        er = 32'({32'd0, val} << (32 - L)); en = val[L-1];
      end
      3'd3, 3'd4, 3'd5: begin
        er = 32'(fld << (32 - L)); en = fld[L-1];
      end
      3'd6: begin
        er = ofs + 32'((first1 < 0) ? L : first1); en = fld[L-1];
      end
      default: begin
        er = 32'(fld); en = fld[L-1];
      end
    endcase
  endtask

  task automatic launch(logic [2:0] o, int base, logic [31:0] ofs, logic [4:0] ln, logic [31:0] val);
    @(negedge clk);
    start = 1'b1; op = o; base_addr = AW'(base); bit_ofs = ofs; field_len = ln; ins_val = val;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output logic [31:0] r, output logic n);
    while (!done) @(negedge clk);
    r = result; n = neg;
  endtask

  task automatic mem_cmp(string req);
    int diffs = 0;
    for (int i = 0; i < MSZ; i++) if (mem[i] !== ref_mem[i]) diffs++;
    chk(req, 32'(diffs), 32'd0);
  endtask

  task automatic run_op(string tag, logic [2:0] o, int base, logic [31:0] ofs,
                        logic [4:0] ln, logic [31:0] val, int seed);
    logic [31:0] er, r; logic en, n; int nb, rd0, wr0; logic wr_op;
    fill(seed);
    for (int i = 0; i < MSZ; i++) ref_mem[i] = mem[i];
    model(o, base, ofs, ln, val, er, en, nb);
    rd0 = rd_cnt; wr0 = wr_cnt;
    launch(o, base, ofs, ln, val);
    chk({tag, " R11 busy"}, 32'(busy), 32'd1);
    wait_done(r, n);
    chk({tag, " result"}, r, er);
    chk({tag, " neg"}, 32'(n), 32'(en));
    @(negedge clk);
    chk({tag, " R11 done single"}, 32'(done), 32'd0);
    chk({tag, " R11 idle"}, 32'(busy), 32'd0);
    wr_op = (o >= 3'd2) && (o <= 3'd5);
    chk({tag, " R3 reads"}, 32'(rd_cnt - rd0), 32'(nb));
    chk({tag, " R10 writes"}, 32'(wr_cnt - wr0), wr_op ? 32'(nb) : 32'd0);
    mem_cmp({tag, " memory"});
  endtask

  task automatic t_reset;
    chk("R11 reset busy", 32'(busy), 32'd0);
    chk("R11 reset done", 32'(done), 32'd0);
    chk("R11 reset req", 32'(mem_req), 32'd0);
  endtask

  task automatic t_extract_u;
    wait_cfg = 0;
    run_op("R5 R4 extu", 3'd0, 20, 32'd3, 5'd5, 32'd0, 1);
    run_op("R1 extu len0", 3'd0, 16, 32'd0, 5'd0, 32'd0, 2);
    wait_cfg = 2;
    run_op("R3 extu five bytes", 3'd0, 16, 32'd7, 5'd0, 32'd0, 3);
    run_op("R5 code7", 3'd7, 24, 32'd13, 5'd9, 32'd0, 4);
  endtask

  task automatic t_extract_s;
    wait_cfg = 1;
    run_op("R6 R2 exts negofs", 3'd1, 30, -32'sd3, 5'd6, 32'd0, 5);
    run_op("R6 R2 exts far neg", 3'd1, 40, -32'sd77, 5'd17, 32'd0, 6);
    run_op("R6 exts", 3'd1, 10, 32'd45, 5'd1, 32'd0, 7);
  endtask

  task automatic t_insert;
    wait_cfg = 0;
    run_op("R7 ins", 3'd2, 20, 32'd5, 5'd12, 32'hFFFA_BCDE, 8);
    wait_cfg = 1;
    run_op("R7 ins 32 span5", 3'd2, 12, 32'd6, 5'd0, 32'h8123_4567, 9);
    run_op("R7 ins neg", 3'd2, 30, -32'sd9, 5'd3, 32'h0000_0005, 10);
  endtask

  task automatic t_modify;
    wait_cfg = 0;
    run_op("R8 chg", 3'd3, 20, 32'd4, 5'd0, 32'd0, 11);
    run_op("R8 clr", 3'd4, 22, 32'd1, 5'd10, 32'd0, 12);
    wait_cfg = 2;
    run_op("R8 set", 3'd5, 18, 32'd7, 5'd26, 32'd0, 13);
    run_op("R8 set zero", 3'd5, 18, 32'd2, 5'd4, 32'd0, -1);
  endtask

  task automatic t_ffo;
    wait_cfg = 0;
    run_op("R9 ffo", 3'd6, 20, 32'd3, 5'd20, 32'd0, 14);
    run_op("R9 ffo zero", 3'd6, 20, -32'sd5, 5'd12, 32'd0, -1);
    run_op("R9 ffo 32", 3'd6, 8, 32'd100, 5'd0, 32'd0, 15);
  endtask

  task automatic t_busy_ignore;
    logic [31:0] er, r; logic en, n; int nb, rd0, wr0, extra;
    wait_cfg = 2;
    fill(16);
    for (int i = 0; i < MSZ; i++) ref_mem[i] = mem[i];
    model(3'd0, 20, 32'd9, 5'd14, 32'd0, er, en, nb);
    rd0 = rd_cnt; wr0 = wr_cnt;
    launch(3'd0, 20, 32'd9, 5'd14, 32'd0);
    @(negedge clk);
    start = 1'b1; op = 3'd5; bit_ofs = 32'd0; field_len = 5'd0; base_addr = AW'(2);
    @(negedge clk);
    start = 1'b0;
    wait_done(r, n);
    chk("R12 mid start result", r, er);
    // collision: a new request in the done cycle
    start = 1'b1; op = 3'd5; base_addr = AW'(4); bit_ofs = 32'd0; field_len = 5'd0;
    @(negedge clk);
    start = 1'b0;
    extra = 0;
    for (int c = 0; c < 8; c++) begin
      if (mem_req || done || busy) extra++;
      @(negedge clk);
    end
    chk("R12 no launch after done-cycle start", 32'(extra), 32'd0);
    chk("R12 reads", 32'(rd_cnt - rd0), 32'(nb));
    chk("R12 writes", 32'(wr_cnt - wr0), 32'd0);
    mem_cmp("R12 memory");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_extract_u;
    t_extract_s;
    t_insert;
    t_modify;
    t_ffo;
    t_busy_ignore;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R11 actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule